// File: doc/BRIEF.md
# Interrupt Priority Resolver

This block picks one winning interrupt line out of up to three 32-line banks. For each line it receives a pending flag, a mask flag, a class-steering flag and a priority field. One input selects which class is being resolved: the normal class or the fast class. The block reports the global number of the most urgent eligible line, together with a flag that says whether any eligible line exists.

A controller runs the resolver once for each class. It uses the same instance twice in succession, or two instances, one with the class input tied high and one tied low. The block only makes the choice. Capturing pending bits, register access and signalling to the processor are done by the logic around it.

The comparison is a balanced tree of two-input nodes, followed by one output register. The number of banks and the width of the priority field are parameters.

Top module: `irq_prio_resolver`

## Requirements
- R1: A line is eligible only when its pending bit is 1, its mask bit is 0, and its steering bit equals `fast_class` (steering 1 means the fast class, steering 0 means the normal class).
- R2: Among eligible lines, the one with the numerically smallest priority value wins; 0 is the most urgent.
- R3: When several eligible lines share the smallest priority value, the one with the largest global line number wins.
- R4: The global line number reported is 32 × bank + bit position within the bank; bit i of each per-line vector is line i, and line i's priority occupies bits [i*PRIO_W +: PRIO_W] of `line_prio`.
- R5: When no line is eligible, `win_line` is 0 and `win_any` is 0.
- R6: `win_any` is 1 whenever some line is eligible, so that a real winner on line 0 gives `win_line`=0 with `win_any`=1.
- R7: Results are registered. `win_line` and `win_any` reflect the inputs present at the preceding rising clock edge, and both are 0 while `rst_n` is low and after reset.
- R8: All PRIO_W bits of the priority take part in the comparison, including the most significant bit.
- R9: A masked line never wins, even when it is pending with the most urgent priority and the right steering.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fast_class | input | 1 | Class being resolved: 1 fast, 0 normal |
| line_pending | input | NLINES | Pending flag per line |
| line_mask | input | NLINES | Mask flag per line (1 blocks the line) |
| line_steer | input | NLINES | Class steering per line (1 fast, 0 normal) |
| line_prio | input | NLINES*PRIO_W | Packed priority fields, line i at [i*PRIO_W +: PRIO_W] |
| win_line | output | IDX_W | Global number of the winning line |
| win_any | output | 1 | At least one eligible line exists |

## Verification
Directed patterns place a single eligible line in different banks to separate bank offset errors from bit-position errors. Line 0 alone is used to separate a real win from the empty result. Fully equal priorities, and pairs that differ only in the top priority bit, expose a wrong tie rule or a truncated comparator. Masked, best-priority lines and wrongly steered lines are used to show that eligibility filtering happens before the comparison. Many random vectors for both classes, some drawn from a narrow priority range so that ties are frequent, are compared against an ascending less-or-equal scan in the bench.

// File: rtl/irr_pkg.sv
package irr_pkg;

  localparam int BANK_LINES = 32;
  localparam int PRIO_MAX_W = 8;

  // Eligible lines of one bank for the class being resolved.
  function automatic logic [BANK_LINES-1:0] bank_eligible(
    input logic [BANK_LINES-1:0] pend,
    input logic [BANK_LINES-1:0] msk,
    input logic [BANK_LINES-1:0] steer,
    input logic                  fast
  );
    logic [BANK_LINES-1:0] cls;
    cls = fast ? steer : ~steer;
    return pend & ~msk & cls;
  endfunction

  // Node decision: 1 takes the higher-numbered (right) child.
  // Equal priorities go right, which mirrors an ascending <= scan.
  function automatic logic prefer_right(
    input logic                  lv,
    input logic [PRIO_MAX_W-1:0] lp,
    input logic                  rv,
    input logic [PRIO_MAX_W-1:0] rp
  );
    return rv && (!lv || (rp <= lp));
  endfunction

  // Global line number from bank and bit.
  function automatic int global_line(input int bank, input int bit_pos);
    return bank * BANK_LINES + bit_pos;
  endfunction

endpackage

// File: rtl/irr_cand_filter.sv
module irr_cand_filter
  import irr_pkg::*;
#(
  parameter int NUM_BANKS = 3,
  localparam int NLINES   = NUM_BANKS * BANK_LINES
) (
  input  logic              fast_class,
  input  logic [NLINES-1:0] pend,
  input  logic [NLINES-1:0] msk,
  input  logic [NLINES-1:0] steer,
  output logic [NLINES-1:0] cand
);

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    localparam int BASE = global_line(b, 0);
    assign cand[BASE +: BANK_LINES] = bank_eligible(pend[BASE +: BANK_LINES],
                                                    msk[BASE +: BANK_LINES],
                                                    steer[BASE +: BANK_LINES],
                                                    fast_class);
  end

endmodule

// File: rtl/irr_tree.sv
module irr_tree
  import irr_pkg::*;
#(
  parameter int NLINES = 96,
  parameter int PRIO_W = 6,
  parameter int IDX_W  = 7
) (
  input  logic [NLINES-1:0]        cand,
  input  logic [NLINES*PRIO_W-1:0] prio,
  output logic                     root_valid,
  output logic [PRIO_W-1:0]        root_prio,
  output logic [IDX_W-1:0]         root_idx
);

  localparam int LVLS  = $clog2(NLINES);
  localparam int NLEAF = 1 << LVLS;
  localparam int NNODE = 2 * NLEAF;

  // Heap layout: node 1 is the root, leaves sit at NLEAF .. NNODE-1,
  // node n has children 2n (lower lines) and 2n+1 (higher lines).
  logic [NNODE-1:0] nv;
  logic [PRIO_W-1:0] np [NNODE];
  logic [IDX_W-1:0]  ni [NNODE];

  assign nv[0] = 1'b0;
  assign np[0] = '0;
  assign ni[0] = '0;

  for (genvar g = 0; g < NLEAF; g++) begin : g_leaf
    if (g < NLINES) begin : g_real
      assign nv[NLEAF+g] = cand[g];
      assign np[NLEAF+g] = prio[g*PRIO_W +: PRIO_W];
      assign ni[NLEAF+g] = IDX_W'(g);
    end else begin : g_pad
      assign nv[NLEAF+g] = 1'b0;
      assign np[NLEAF+g] = '0;
      assign ni[NLEAF+g] = '0;
    end
  end

  for (genvar n = 1; n < NLEAF; n++) begin : g_node
    logic take_r;
    assign take_r = prefer_right(nv[2*n],   PRIO_MAX_W'(np[2*n]),
                                 nv[2*n+1], PRIO_MAX_W'(np[2*n+1]));
    assign nv[n] = nv[2*n] | nv[2*n+1];
    assign np[n] = take_r ? np[2*n+1] : np[2*n];
    assign ni[n] = take_r ? ni[2*n+1] : ni[2*n];
  end

  assign root_valid = nv[1];
  assign root_prio  = np[1];
  assign root_idx   = ni[1];

  // Root against every leaf: nothing more urgent, no higher tied line.
  always_comb begin
    for (int i = 0; i < NLINES; i++) begin
      if (cand[i]) begin
        p_found_any_r6: assert (root_valid);
        p_no_better_prio_r2: assert (prio[i*PRIO_W +: PRIO_W] >= root_prio);
        p_tie_high_index_r3: assert (prio[i*PRIO_W +: PRIO_W] != root_prio
                                     || IDX_W'(i) <= root_idx);
      end
    end
  end

endmodule

// File: rtl/irr_out_reg.sv
module irr_out_reg #(
  parameter int IDX_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [IDX_W-1:0] in_idx,
  output logic             out_any,
  output logic [IDX_W-1:0] out_line
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_any  <= 1'b0;
      out_line <= '0;
    end else begin
      out_any  <= in_valid;
      out_line <= in_valid ? in_idx : '0;
    end
  end

  p_empty_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !out_any |-> out_line == '0);

  p_follow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (out_any && out_line == $past(in_idx)));

endmodule

// File: rtl/irq_prio_resolver.sv
module irq_prio_resolver
  import irr_pkg::*;
#(
  parameter int  NUM_BANKS = 3,
  parameter int  PRIO_W    = 6,
  localparam int NLINES    = NUM_BANKS * BANK_LINES,
  localparam int IDX_W     = $clog2(NLINES)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     fast_class,
  input  logic [NLINES-1:0]        line_pending,
  input  logic [NLINES-1:0]        line_mask,
  input  logic [NLINES-1:0]        line_steer,
  input  logic [NLINES*PRIO_W-1:0] line_prio,
  output logic [IDX_W-1:0]         win_line,
  output logic                     win_any
);

  logic [NLINES-1:0] cand_vec;
  logic              root_valid;
  logic [PRIO_W-1:0] root_prio;
  logic [IDX_W-1:0]  root_idx;

  irr_cand_filter #(.NUM_BANKS(NUM_BANKS)) u_filter (
    .fast_class (fast_class),
    .pend       (line_pending),
    .msk        (line_mask),
    .steer      (line_steer),
    .cand       (cand_vec)
  );

  irr_tree #(.NLINES(NLINES), .PRIO_W(PRIO_W), .IDX_W(IDX_W)) u_tree (
    .cand       (cand_vec),
    .prio       (line_prio),
    .root_valid (root_valid),
    .root_prio  (root_prio),
    .root_idx   (root_idx)
  );

  irr_out_reg #(.IDX_W(IDX_W)) u_out (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (root_valid),
    .in_idx   (root_idx),
    .out_any  (win_any),
    .out_line (win_line)
  );

  // The chosen leaf must be pending, unmasked and of the resolved class.
  p_winner_eligible_r9: assert property (@(posedge clk) disable iff (!rst_n)
    root_valid |-> (line_pending[root_idx] && !line_mask[root_idx]));

  p_winner_class_r1: assert property (@(posedge clk) disable iff (!rst_n)
    root_valid |-> (line_steer[root_idx] == fast_class));

  p_any_tracks_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (|cand_vec) |=> win_any);

endmodule

// File: tb/irq_prio_resolver_test.sv
module irq_prio_resolver_test;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int NB = 3;
  localparam int PW = 6;
  localparam int NL = NB * 32;
  localparam int IW = $clog2(NL);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fast_class = 1'b0;
  logic [NL-1:0] line_pending = '0;
  logic [NL-1:0] line_mask = '0;
  logic [NL-1:0] line_steer = '0;
  logic [NL*PW-1:0] line_prio = '0;
  logic [IW-1:0] win_line;
  logic win_any;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  int pr [NL];

  always #2.5 clk = ~clk;

  irq_prio_resolver #(.NUM_BANKS(NB), .PRIO_W(PW)) uut (
    .clk(clk), .rst_n(rst_n), .fast_class(fast_class),
    .line_pending(line_pending), .line_mask(line_mask),
    .line_steer(line_steer), .line_prio(line_prio),
    .win_line(win_line), .win_any(win_any)
  );

  task automatic check(input string req, input int exp_line, input bit exp_any);
    n_run++;
    if (int'(win_line) != exp_line || win_any != exp_any) begin
      n_fail++;
      $display("FAIL %s: line=%0d any=%0d, expected line=%0d any=%0d",
               req, win_line, win_any, exp_line, exp_any);
    end
  endtask

  task automatic clear_all();
    line_pending = '0;
    line_mask = '0;
    line_steer = '0;
    for (int i = 0; i < NL; i++) pr[i] = 0;
  endtask

  // Pack priorities, let one edge pass, sample at the next falling edge.
  task automatic apply();
    for (int i = 0; i < NL; i++) line_prio[i*PW +: PW] = PW'(pr[i]);
    @(negedge clk);
  endtask

  // Ascending scan with <=: the last most-urgent eligible line is kept.
  task automatic ref_pick(output int line, output bit any);
    int best;
    line = 0;
    any = 0;
    best = 0;
    for (int i = 0; i < NL; i++) begin
      if (line_pending[i] && !line_mask[i] && line_steer[i] == fast_class) begin
        if (!any || pr[i] <= best) begin
          best = pr[i];
          line = i;
          any = 1;
        end
      end
    end
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R7 reset", 0, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R7 after reset", 0, 0);
  endtask

  task automatic t_empty();
    clear_all();
    line_pending = '1;
    line_mask = '1;
    apply();
    check("R5 all masked", 0, 0);
    line_mask = '0;
    line_steer = '1;
    fast_class = 1'b0;
    apply();
    check("R5 R1 all steered to other class", 0, 0);
  endtask

  task automatic t_line_zero();
    clear_all();
    fast_class = 1'b0;
    line_pending[0] = 1'b1;
    pr[0] = 17;
    apply();
    check("R6 line zero alone", 0, 1);
  endtask

  task automatic t_bank_index();
    clear_all();
    line_pending[37] = 1'b1;
    apply();
    check("R4 bank1 bit5", 37, 1);
    clear_all();
    line_pending[69] = 1'b1;
    apply();
    check("R4 bank2 bit5", 69, 1);
  endtask

  task automatic t_ties();
    clear_all();
    fast_class = 1'b0;
    line_pending = '1;
    for (int i = 0; i < NL; i++) pr[i] = 9;
    apply();
    check("R3 all equal normal", NL - 1, 1);
    line_steer[10] = 1'b1;
    line_steer[20] = 1'b1;
    fast_class = 1'b1;
    apply();
    check("R3 R1 equal fast pair", 20, 1);
  endtask

  task automatic t_prio();
    clear_all();
    fast_class = 1'b0;
    line_pending[95] = 1'b1; pr[95] = 5;
    line_pending[3]  = 1'b1; pr[3]  = 0;
    apply();
    check("R2 low line more urgent", 3, 1);
    clear_all();
    line_pending[40] = 1'b1; pr[40] = 32;
    line_pending[41] = 1'b1; pr[41] = 31;
    apply();
    check("R8 top priority bit", 41, 1);
    clear_all();
    line_pending[50] = 1'b1; pr[50] = 62;
    line_pending[51] = 1'b1; pr[51] = 63;
    apply();
    check("R8 largest values", 50, 1);
  endtask

  task automatic t_mask();
    clear_all();
    fast_class = 1'b0;
    line_pending[60] = 1'b1; pr[60] = 0;
    line_pending[30] = 1'b1; pr[30] = 40;
    line_mask[60] = 1'b1;
    apply();
    check("R9 urgent line masked", 30, 1);
  endtask

  task automatic t_class();
    clear_all();
    line_pending[12] = 1'b1; pr[12] = 3; line_steer[12] = 1'b1;
    line_pending[80] = 1'b1; pr[80] = 7;
    fast_class = 1'b1;
    apply();
    check("R1 fast class", 12, 1);
    fast_class = 1'b0;
    apply();
    check("R1 normal class", 80, 1);
  endtask

  task automatic t_latency();
    clear_all();
    line_pending[7] = 1'b1;
    apply();
    line_pending[7] = 1'b0;
    line_pending[8] = 1'b1;
    #1;
    check("R7 output held before edge", 7, 1);
    @(negedge clk);
    check("R7 output after edge", 8, 1);
  endtask

  task automatic t_random(input int rounds, input int pmax);
    int el;
    bit ea;
    for (int r = 0; r < rounds; r++) begin
      for (int i = 0; i < NL; i++) begin
        line_pending[i] = 1'($urandom_range(0, 1));
        line_mask[i] = ($urandom_range(0, 3) == 0);
        line_steer[i] = 1'($urandom_range(0, 1));
        pr[i] = $urandom_range(0, pmax);
      end
      fast_class = 1'($urandom_range(0, 1));
      apply();
      ref_pick(el, ea);
      check(pmax < 4 ? "R3 random ties" : "R2 random", el, ea);
    end
  endtask

  initial begin
    #(200000 * 5.0);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_empty();
    t_line_zero();
    t_bank_index();
    t_ties();
    t_prio();
    t_mask();
    t_class();
    t_latency();
    t_random(300, 63);
    t_random(300, 2);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule